// File: doc/BRIEF.md
# Self-Calibrating Serial Register Access Port

This block is a full-duplex serial debug port. Through it a tool outside the chip reads and writes bytes in an internal register space of 128 eight-bit locations. The port has no configured baud rate. After every reset it watches the receive line for one calibration byte of alternating ones and zeros, and it derives its bit period from that byte. All later framing, in both directions, uses the period it measured.

After calibration, each exchange starts with a command byte. Its top bit selects a read or a write, and its lower seven bits give a register address. A write command is followed by one data byte, which is then placed on the parallel register bus with a one-cycle write strobe. A read command causes a one-cycle read strobe. The register file answers one cycle later, and that byte is sent back on the transmit line. A wider register is reached as a run of byte exchanges at consecutive addresses, so a 32-bit value takes four of them.

Every frame is a low start bit followed by eight data bits, most significant bit first. The line idles high between frames. The receiver samples each bit near its centre. A low pulse that has already ended by the half-bit point is discarded as noise.

Top module: `regport_uart`

## Requirements
- R1: From reset until the calibration byte 0xAA has been fully measured, uart_tx stays high and neither reg_we nor reg_re is asserted. Bytes received during calibration cause no register access.
- R2: The bit period equals the mean of the first low pulse (the start bit) and the first high pulse (bit 7) of the calibration byte. A later reset discards it, and the next calibration byte sets a new rate.
- R3: A frame is one low start bit, then eight data bits, bit 7 first and bit 0 last, each one bit period long. Received bits are sampled at mid-bit, and the line idles high.
- R4: In a command byte, bit 7 is the direction (0 = write, 1 = read) and bits 6..0 are the register address, covering 0x00 to 0x7F.
- R5: After a write command and its data byte, reg_we is high for exactly one cycle, with reg_addr equal to the command address and reg_wdata equal to the data byte.
- R6: After a read command, reg_re is high for exactly one cycle with reg_addr equal to the command address. reg_rdata is taken on the cycle after that strobe and sent on uart_tx in the R3 frame format. reg_we and reg_re are never high together.
- R7: The falling edge of a read response's start bit on uart_tx comes only after the command's bit 0 has been sampled, which is no earlier than half a bit period into that bit.
- R8: If the receive line falls but is high again at the half-bit sample, the event is dropped: no byte is taken and no access occurs, and the next real frame is received normally.
- R9: Consecutive exchanges separated by one idle bit period are each handled fully. Four writes to consecutive addresses followed by four reads return the 32-bit value intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; calibration is required again afterwards |
| uart_rx | input | 1 | Serial receive line, idle high |
| uart_tx | output | 1 | Serial transmit line, idle high |
| reg_addr | output | 7 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Register read data, valid the cycle after reg_re |

## Verification
A wrong measured period does not show at once. It first appears as a bit shifted by one position in a write's data or a read's response, and after a few frames as lost or misread bytes, so the tests read back every value they write. A control state that stalls or skips appears within one frame: either a strobe is missing from the register bus after a command byte, or uart_tx goes low when no read is pending. The bench checks for the second of these on every clock.

// File: rtl/regport_uart_pkg.sv
package regport_uart_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = DATA_W - 1;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  typedef enum logic [2:0] {
    ST_CAL, ST_IDLE, ST_PROC, ST_WDATA, ST_RWAIT, ST_RCAP, ST_SEND
  } fsm_t;
endpackage

// File: rtl/regport_uart_calib.sv
module regport_uart_calib #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line,
  output logic             done,
  output logic [CNT_W-1:0] period
);
  localparam int FL_W = CNT_W + 3;

  typedef enum logic [2:0] {C_WAIT, C_LOW, C_HIGH, C_FLUSH, C_DONE} cst_t;

  cst_t             st;
  logic             prev;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] low_len;
  logic [CNT_W:0]   sum;
  logic [FL_W-1:0]  fcnt;
  logic [FL_W-1:0]  p_ext;
  logic [FL_W-1:0]  flush_lim;

  // Remaining seven bits of the preamble plus half a bit of idle.
  always_comb begin
    p_ext     = {3'b000, period};
    flush_lim = (p_ext << 3) - p_ext + (p_ext >> 1);
    sum       = {1'b0, low_len} + {1'b0, cnt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= C_WAIT;
      prev    <= 1'b1;
      cnt     <= '0;
      low_len <= '0;
      fcnt    <= '0;
      period  <= '0;
      done    <= 1'b0;
    end else begin
      prev <= line;
      case (st)
        C_WAIT: if (prev && !line) begin
          st  <= C_LOW;
          cnt <= CNT_W'(1);
        end
        C_LOW: begin
          if (line) begin
            low_len <= cnt;
            cnt     <= CNT_W'(1);
            st      <= C_HIGH;
          end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
          end
        end
        C_HIGH: begin
          if (!line) begin
            period <= CNT_W'(sum >> 1);
            fcnt   <= FL_W'(1);
            st     <= C_FLUSH;
          end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
          end
        end
        C_FLUSH: begin
          if (fcnt >= flush_lim) begin
            st   <= C_DONE;
            done <= 1'b1;
          end else begin
            fcnt <= fcnt + 1'b1;
          end
        end
        default: st <= C_DONE;
      endcase
    end
  end

  // R2: a finished calibration always leaves a usable period
  a_r2_period_nonzero: assert property (@(posedge clk) disable iff (rst)
    done |-> (period != '0));

  // R1: calibration, once finished, holds until the next reset
  a_r1_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
endmodule

// File: rtl/regport_uart_rx.sv
module regport_uart_rx
  import regport_uart_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              line,
  input  logic [CNT_W-1:0]  period,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA} rst_t;

  rst_t             st;
  logic             prev;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [CNT_W-1:0] half;

  always_comb half = period >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= R_IDLE;
      prev  <= 1'b1;
      cnt   <= '0;
      bitn  <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      prev  <= line;
      valid <= 1'b0;
      case (st)
        R_IDLE: if (en && prev && !line) begin
          st  <= R_START;
          cnt <= '0;
        end
        R_START: begin
          if (cnt == half) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= line ? R_IDLE : R_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        R_DATA: begin
          if (cnt == period - 1'b1) begin
            cnt  <= '0;
            data <= {data[DATA_W-2:0], line};
            bitn <= bitn + 1'b1;
            if (bitn == 3'd7) begin
              valid <= 1'b1;
              st    <= R_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  // R3: each received byte is announced by a single-cycle pulse
  a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
endmodule

// File: rtl/regport_uart_tx.sv
module regport_uart_tx
  import regport_uart_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  period,
  output logic              txd,
  output logic              done
);
  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [3:0]        idx;
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      txd  <= 1'b1;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy <= 1'b1;
          txd  <= 1'b0;
          sh   <= din;
          idx  <= '0;
          cnt  <= '0;
        end
      end else if (cnt == period - 1'b1) begin
        cnt <= '0;
        if (idx == 4'(DATA_W)) begin
          txd  <= 1'b1;
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          txd <= sh[DATA_W-1];
          sh  <= {sh[DATA_W-2:0], 1'b0};
          idx <= idx + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: the line rests high whenever no frame is being shifted out
  a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> txd);
endmodule

// File: rtl/regport_uart.sv
module regport_uart
  import regport_uart_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uart_rx,
  output logic              uart_tx,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic [1:0]        rx_sync;
  logic              line;
  logic              cal_done;
  logic [CNT_W-1:0]  period;
  logic              rx_valid;
  logic [DATA_W-1:0] rx_data;
  logic              tx_go;
  logic              tx_done;
  logic [DATA_W-1:0] tx_byte;
  cmd_t              cmd;
  fsm_t              st;

  always_ff @(posedge clk) begin
    if (rst) rx_sync <= 2'b11;
    else     rx_sync <= {rx_sync[0], uart_rx};
  end
  assign line = rx_sync[1];

  regport_uart_calib #(.CNT_W(CNT_W)) u_calib (
    .clk(clk), .rst(rst), .line(line), .done(cal_done), .period(period)
  );

  regport_uart_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .en(cal_done), .line(line), .period(period),
    .valid(rx_valid), .data(rx_data)
  );

  regport_uart_tx #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .go(tx_go), .din(tx_byte), .period(period),
    .txd(uart_tx), .done(tx_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_CAL;
      cmd       <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      tx_go     <= 1'b0;
      tx_byte   <= '0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      tx_go  <= 1'b0;
      case (st)
        ST_CAL:   if (cal_done) st <= ST_IDLE;
        ST_IDLE:  if (rx_valid) begin
          cmd <= cmd_t'(rx_data);
          st  <= ST_PROC;
        end
        ST_PROC: begin
          reg_addr <= cmd.addr;
          if (cmd.rd) begin
            reg_re <= 1'b1;
            st     <= ST_RWAIT;
          end else begin
            st <= ST_WDATA;
          end
        end
        ST_WDATA: if (rx_valid) begin
          reg_wdata <= rx_data;
          reg_we    <= 1'b1;
          st        <= ST_IDLE;
        end
        ST_RWAIT: st <= ST_RCAP;
        ST_RCAP: begin
          tx_byte <= reg_rdata;
          tx_go   <= 1'b1;
          st      <= ST_SEND;
        end
        ST_SEND:  if (tx_done) st <= ST_IDLE;
        default:  st <= ST_CAL;
      endcase
    end
  end

  // R1: no register traffic before the rate is known
  a_r1_no_access_uncal: assert property (@(posedge clk) disable iff (rst)
    !cal_done |-> !(reg_we || reg_re));

  // R6: read and write strobes are exclusive
  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_we, reg_re}));

  // R5: a write strobe lasts one cycle
  a_r5_we_single: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R7: the transmit line only moves while a read response is owed
  a_r7_tx_quiet: assert property (@(posedge clk) disable iff (rst)
    (st != ST_SEND) |-> uart_tx);
endmodule

// File: tb/tb_regport_uart.sv
module tb_regport_uart;
  logic       clk = 1'b0;
  logic       rst;
  logic       rxd;
  logic       txd;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic       reg_re;
  logic [7:0] reg_rdata;

  logic [7:0]  regs   [128];
  logic [7:0]  mirror [128];
  logic [15:0] acc_q[$];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int bitp   = 16;
  int d0_cyc = 0;
  int fall_cyc = 0;
  bit rd_active = 1'b0;

  always #5 clk = ~clk;

  regport_uart dut (
    .clk(clk), .rst(rst), .uart_rx(rxd), .uart_tx(txd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  // Register file behind the bus: one-cycle read latency.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (reg_we) regs[reg_addr] <= reg_wdata;
    if (reg_re) reg_rdata <= regs[reg_addr];
  end

  // Per-clock observation: log bus strobes, and demand a quiet tx line
  // whenever no read response is owed (R1, R7).
  always @(negedge clk) begin
    if (reg_we) acc_q.push_back({1'b0, reg_addr, reg_wdata});
    if (reg_re) acc_q.push_back({1'b1, reg_addr, 8'h00});
    if (rst === 1'b0 && !rd_active) begin
      checks++;
      if (txd !== 1'b1) begin
        fails++;
        $display("FAIL R7 tx active without a read at cycle %0d act=%b exp=1", cyc, txd);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rxd = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    acc_q.delete();
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bitp) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) d0_cyc = cyc;
      rxd = b[i];
      repeat (bitp) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic recv_byte(output logic [7:0] b, output bit ok);
    int t = 0;
    ok = 1'b1;
    b = 8'h00;
    while (txd !== 1'b0 && t < 40 * bitp) begin
      @(negedge clk);
      t++;
    end
    if (txd !== 1'b0) ok = 1'b0;
    fall_cyc = cyc;
    repeat (bitp / 2) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      repeat (bitp) @(negedge clk);
      b[i] = txd;
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d);
    logic [15:0] e;
    send_byte({1'b0, a}, bitp);
    send_byte(d, bitp);
    repeat (4) @(negedge clk);
    mirror[a] = d;
    chk("R5 write strobe count", acc_q.size(), 1);
    if (acc_q.size() >= 1) begin
      e = acc_q.pop_front();
      chk("R5/R4 write addr+data", e, {1'b0, a, d});
    end
    acc_q.delete();
  endtask

  task automatic do_read(input logic [6:0] a, output logic [7:0] got);
    bit ok;
    logic [15:0] e;
    rd_active = 1'b1;
    fork
      send_byte({1'b1, a}, bitp);
      recv_byte(got, ok);
    join
    repeat (bitp) @(negedge clk);
    rd_active = 1'b0;
    chk("R6 response frame seen", ok, 1);
    chk("R6/R3 response byte", got, mirror[a]);
    chk("R7 response after command bit 0", (fall_cyc >= d0_cyc + bitp / 2), 1);
    chk("R6 read strobe count", acc_q.size(), 1);
    if (acc_q.size() >= 1) begin
      e = acc_q.pop_front();
      chk("R4 read addr", e, {1'b1, a, 8'h00});
    end
    acc_q.delete();
  endtask

  initial begin
    logic [7:0]  got;
    logic [31:0] word;
    for (int k = 0; k < 128; k++) begin
      regs[k]   = 8'(k * 3) ^ 8'hA5;
      mirror[k] = 8'(k * 3) ^ 8'hA5;
    end
    reg_rdata = 8'h00;
    do_reset();
    repeat (20) @(negedge clk);
    chk("R1 tx idle after reset", txd, 1);
    chk("R1 no access after reset", acc_q.size(), 0);

    // Calibration byte: no access may result from it.
    send_byte(8'hAA, bitp);
    repeat (10) @(negedge clk);
    chk("R1 no access during calibration", acc_q.size(), 0);

    // Basic write and read back (R2 rate learned, R4, R5, R6).
    do_write(7'h05, 8'h3C);
    do_read(7'h05, got);
    // Boundary addresses and preloaded content.
    do_read(7'h7F, got);
    do_write(7'h00, 8'hFF);
    do_read(7'h00, got);
    do_write(7'h7F, 8'h01);
    do_read(7'h7F, got);
    // Bit ordering: single MSB and single LSB (R3).
    do_write(7'h22, 8'h80);
    do_read(7'h22, got);
    chk("R3 msb position", got, 8'h80);
    do_write(7'h23, 8'h01);
    do_read(7'h23, got);
    chk("R3 lsb position", got, 8'h01);

    // Glitch on the receive line is dropped (R8).
    @(negedge clk);
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * bitp) @(negedge clk);
    chk("R8 glitch causes no access", acc_q.size(), 0);
    do_write(7'h40, 8'h5A);
    do_read(7'h40, got);
    chk("R8 receiver intact after glitch", got, 8'h5A);

    // 32-bit register through four byte exchanges (R9).
    do_write(7'h10, 8'hDE);
    do_write(7'h11, 8'hAD);
    do_write(7'h12, 8'hBE);
    do_write(7'h13, 8'hEF);
    word = 32'h0;
    for (int k = 0; k < 4; k++) begin
      do_read(7'(16 + k), got);
      word = {word[23:0], got};
    end
    chk("R9 32-bit word", word, 32'hDEADBEEF);

    // New reset, new rate (R2, R1).
    do_reset();
    bitp = 24;
    repeat (20) @(negedge clk);
    chk("R1 tx idle after second reset", txd, 1);
    send_byte(8'hAA, bitp);
    repeat (10) @(negedge clk);
    chk("R1 no access during second calibration", acc_q.size(), 0);
    do_write(7'h31, 8'hC3);
    do_read(7'h31, got);
    chk("R2 data at relearned rate", got, 8'hC3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule